// File: doc/BRIEF.md
# Interprocessor Interrupt Destination Resolver

This block sits inside a per-processor local interrupt controller. When software writes the low half of the interrupt command register, the block works out which processors the interprocessor interrupt is for. It uses the shorthand, the destination mode, the destination byte, this processor's own ID and the number of processors present. If this processor is one of the targets, it does not send itself a message. It raises a direct local request instead.

Every other target is placed in a bitmap. A serializer then sends one message per handshake on a valid/ready port, walking the bitmap from the lowest ID upward. Each message carries the target ID, vector, delivery mode, trigger mode and level. A saturating counter of pending interprocessor interrupts grows by the number of messages that each accepted write produces.

Lowest-priority arbitration, the bus packet format and register read-back are not part of this block.

Top module: `ipi_dest_resolver`

## Requirements
- R1: After reset, `local_req`, `err_lowprio`, `msg_valid` and `busy` are low and `pending_cnt` is zero.
- R2: Shorthand 0 with `cmd_dest_logical` high selects processor i for each set bit i of `cmd_dest`, ignoring bits at or above `num_proc`. If the bit for `self_id` is set, a local request is raised and no message goes to `self_id`.
- R3: Shorthand 0 in physical mode with `cmd_dest` = 0xFF sends a message to every processor below `num_proc` except `self_id`, and also raises a local request.
- R4: Shorthand 0 in physical mode with `cmd_dest` equal to `self_id` raises only a local request. Any other `cmd_dest` below `num_proc` produces exactly one message to that ID. Any other value produces nothing.
- R5: Shorthand 1 raises only a local request and sends no message.
- R6: Shorthand 2 raises a local request and sends a message to every processor below `num_proc` except `self_id`.
- R7: Shorthand 3 sends a message to every processor below `num_proc` except `self_id`, and raises no local request.
- R8: Shorthand 0 with delivery mode code 3'b001 (lowest priority) pulses `err_lowprio` in the cycle after the write. It raises no local request, sends no message and leaves `pending_cnt` unchanged. Other shorthands accept that code.
- R9: In the cycle after an accepted write, `pending_cnt` has grown by the number of messages that write produces. It saturates at its maximum and never decreases.
- R10: Messages leave in ascending target-ID order, one per cycle in which `msg_valid` and `msg_ready` are both high. Each message carries the vector, delivery mode, trigger and level of its write, and holds steady while stalled. `busy` stays high until the last message is accepted.
- R11: A command write while `busy` is high is ignored. It raises no local request, changes no count and alters no message in flight.
- R12: `local_req` is a one-cycle pulse in the cycle after the write. It comes with the write's vector, delivery mode and trigger on `local_vector`, `local_dmode` and `local_trigger`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_shorthand | input | 2 | Destination shorthand (0 field, 1 self, 2 all, 3 all but self) |
| cmd_dest_logical | input | 1 | Destination mode: 1 logical bitmask, 0 physical ID |
| cmd_dest | input | DEST_W | Destination byte |
| cmd_dmode | input | 3 | Delivery mode code |
| cmd_vector | input | VW | Interrupt vector |
| cmd_trigger | input | 1 | Trigger mode |
| cmd_level | input | 1 | Level bit |
| self_id | input | IDW | This processor's ID |
| num_proc | input | IDW+1 | Number of processors present |
| local_req | output | 1 | Local interrupt request pulse |
| local_vector | output | VW | Vector of the local request |
| local_dmode | output | 3 | Delivery mode of the local request |
| local_trigger | output | 1 | Trigger mode of the local request |
| err_lowprio | output | 1 | Unsupported lowest-priority request pulse |
| busy | output | 1 | Outbound messages still pending |
| msg_valid | output | 1 | Outbound message valid |
| msg_ready | input | 1 | Outbound message accepted |
| msg_dest | output | IDW | Target processor ID |
| msg_vector | output | VW | Message vector |
| msg_dmode | output | 3 | Message delivery mode |
| msg_trigger | output | 1 | Message trigger mode |
| msg_level | output | 1 | Message level |
| pending_cnt | output | CNTW | Pending interprocessor interrupt count |

## Verification
The bench sweeps every destination byte in both destination modes, for several processor counts and own-ID positions.

- **Self handling.** A resolver that treated its own ID like any other would send itself a message and never pulse the local request.
- **Processor-count mask.** One that ignored the count would emit messages to IDs that do not exist.
- **Broadcast ID.** One that mishandled 0xFF would send a single message to an out-of-range ID.
- **Lowest-priority rejection.** Lowest-priority writes under shorthand 0 are checked to produce only the error pulse and no count change.
- **Writes while busy.** A write made during a busy burst is checked to leave the burst, the count and the local request untouched.
- **Ordering under stall.** A pseudo-random ready pattern stalls the port, so an out-of-order scan, or a message that changes while stalled, would be caught.
- **Counter saturation.** The counter is driven past its saturation point.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  localparam logic [1:0] SH_FIELD    = 2'd0;
  localparam logic [1:0] SH_SELF     = 2'd1;
  localparam logic [1:0] SH_ALL_INCL = 2'd2;
  localparam logic [1:0] SH_ALL_EXCL = 2'd3;

  localparam logic [2:0] DM_LOWPRIO  = 3'b001;

  // Number of set bits in a target map.
  function automatic int unsigned count_ones(input logic [63:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 64; i++) n += int'(v[i]);
    return n;
  endfunction

  // Index of the lowest set bit (0 when none is set).
  function automatic int unsigned lowest_set(input logic [63:0] v);
    int unsigned r;
    r = 0;
    for (int i = 63; i >= 0; i--) if (v[i]) r = i;
    return r;
  endfunction

endpackage

// File: rtl/ipi_target_decode.sv
module ipi_target_decode #(
  parameter int NPROC  = 8,
  parameter int DEST_W = 8,
  parameter int IDW    = 3
) (
  input  logic [1:0]        shorthand,
  input  logic              dest_logical,
  input  logic [DEST_W-1:0] dest,
  input  logic [2:0]        dmode,
  input  logic [IDW-1:0]    self_id,
  input  logic [IDW:0]      num_proc,
  output logic [NPROC-1:0]  targets,
  output logic              self_hit,
  output logic              bad_mode
);
  import ipi_pkg::*;

  logic [NPROC-1:0] present;
  logic [NPROC-1:0] is_self;
  logic [NPROC-1:0] phys_hit;

  for (genvar i = 0; i < NPROC; i++) begin : g_slot
    assign present[i]  = num_proc > (IDW+1)'(i);
    assign is_self[i]  = self_id == IDW'(i);
    assign phys_hit[i] = dest == DEST_W'(i);
  end

  logic [NPROC-1:0] others;
  logic [NPROC-1:0] logical_sel;
  assign others      = present & ~is_self;
  assign logical_sel = dest[NPROC-1:0] & present;

  always_comb begin
    targets  = '0;
    self_hit = 1'b0;
    bad_mode = 1'b0;
    unique case (shorthand)
      SH_FIELD: begin
        if (dmode == DM_LOWPRIO) begin
          bad_mode = 1'b1;
        end else if (dest_logical) begin
          targets  = logical_sel & ~is_self;
          self_hit = |(logical_sel & is_self);
        end else if (&dest) begin
          targets  = others;
          self_hit = 1'b1;
        end else if (dest == DEST_W'(self_id)) begin
          self_hit = 1'b1;
        end else begin
          targets  = phys_hit & present;
        end
      end
      SH_SELF:     self_hit = 1'b1;
      SH_ALL_INCL: begin
        targets  = others;
        self_hit = 1'b1;
      end
      default:     targets = others;
    endcase
  end
endmodule

// File: rtl/ipi_msg_serializer.sv
module ipi_msg_serializer #(
  parameter int NPROC = 8,
  parameter int IDW   = 3,
  parameter int VW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NPROC-1:0] load_map,
  input  logic [VW-1:0]    load_vector,
  input  logic [2:0]       load_dmode,
  input  logic             load_trigger,
  input  logic             load_level,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [IDW-1:0]   msg_dest,
  output logic [VW-1:0]    msg_vector,
  output logic [2:0]       msg_dmode,
  output logic             msg_trigger,
  output logic             msg_level
);
  import ipi_pkg::*;

  logic [NPROC-1:0] pend_q;
  logic             fire;
  logic [IDW-1:0]   pick;

  assign pick      = IDW'(lowest_set(64'(pend_q)));
  assign msg_valid = |pend_q;
  assign msg_dest  = pick;
  assign fire      = msg_valid & msg_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= '0;
      msg_vector  <= '0;
      msg_dmode   <= '0;
      msg_trigger <= 1'b0;
      msg_level   <= 1'b0;
    end else if (load) begin
      pend_q      <= load_map;
      msg_vector  <= load_vector;
      msg_dmode   <= load_dmode;
      msg_trigger <= load_trigger;
      msg_level   <= load_level;
    end else if (fire) begin
      pend_q[pick] <= 1'b0;
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready && !load |=> msg_valid && $stable(msg_dest) && $stable(msg_vector)) // R10
    else $error("stalled message changed");
  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !load |=> !msg_valid || (msg_dest > $past(msg_dest))) // R10
    else $error("messages out of order");
endmodule

// File: rtl/ipi_pending_count.sv
module ipi_pending_count #(
  parameter int NPROC = 8,
  parameter int CNTW  = 8,
  parameter int AW    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            add_en,
  input  logic [AW-1:0]   add_val,
  output logic [CNTW-1:0] count
);
  logic [CNTW:0] sum;
  assign sum = {1'b0, count} + (CNTW+1)'(add_val);

  always_ff @(posedge clk) begin
    if (!rst_n)      count <= '0;
    else if (add_en) count <= sum[CNTW] ? '1 : sum[CNTW-1:0];
  end

  AST_NEVER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    count >= $past(count)) // R9
    else $error("pending count decreased");
endmodule

// File: rtl/ipi_dest_resolver.sv
module ipi_dest_resolver #(
  parameter int NPROC  = 8,
  parameter int DEST_W = 8,
  parameter int VW     = 8,
  parameter int CNTW   = 8,
  localparam int IDW   = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int AW    = $clog2(NPROC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [1:0]        cmd_shorthand,
  input  logic              cmd_dest_logical,
  input  logic [DEST_W-1:0] cmd_dest,
  input  logic [2:0]        cmd_dmode,
  input  logic [VW-1:0]     cmd_vector,
  input  logic              cmd_trigger,
  input  logic              cmd_level,
  input  logic [IDW-1:0]    self_id,
  input  logic [IDW:0]      num_proc,
  output logic              local_req,
  output logic [VW-1:0]     local_vector,
  output logic [2:0]        local_dmode,
  output logic              local_trigger,
  output logic              err_lowprio,
  output logic              busy,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [IDW-1:0]    msg_dest,
  output logic [VW-1:0]    msg_vector,
  output logic [2:0]        msg_dmode,
  output logic              msg_trigger,
  output logic              msg_level,
  output logic [CNTW-1:0]   pending_cnt
);
  import ipi_pkg::*;

  logic [NPROC-1:0] targets;
  logic             self_hit;
  logic             bad_mode;
  logic             accept;
  logic             load;
  logic [AW-1:0]    n_msgs;

  ipi_target_decode #(.NPROC(NPROC), .DEST_W(DEST_W), .IDW(IDW)) u_decode (
    .shorthand   (cmd_shorthand),
    .dest_logical(cmd_dest_logical),
    .dest        (cmd_dest),
    .dmode       (cmd_dmode),
    .self_id     (self_id),
    .num_proc    (num_proc),
    .targets     (targets),
    .self_hit    (self_hit),
    .bad_mode    (bad_mode)
  );

  assign accept = cmd_wr & ~busy;
  assign load   = accept & (|targets);
  assign n_msgs = AW'(count_ones(64'(targets)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      local_req     <= 1'b0;
      local_vector  <= '0;
      local_dmode   <= '0;
      local_trigger <= 1'b0;
      err_lowprio   <= 1'b0;
    end else begin
      local_req   <= accept & self_hit;
      err_lowprio <= accept & bad_mode;
      if (accept & self_hit) begin
        local_vector  <= cmd_vector;
        local_dmode   <= cmd_dmode;
        local_trigger <= cmd_trigger;
      end
    end
  end

  ipi_msg_serializer #(.NPROC(NPROC), .IDW(IDW), .VW(VW)) u_serial (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load),
    .load_map    (targets),
    .load_vector (cmd_vector),
    .load_dmode  (cmd_dmode),
    .load_trigger(cmd_trigger),
    .load_level  (cmd_level),
    .msg_valid   (msg_valid),
    .msg_ready   (msg_ready),
    .msg_dest    (msg_dest),
    .msg_vector  (msg_vector),
    .msg_dmode   (msg_dmode),
    .msg_trigger (msg_trigger),
    .msg_level   (msg_level)
  );

  assign busy = msg_valid;

  ipi_pending_count #(.NPROC(NPROC), .CNTW(CNTW), .AW(AW)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .add_en (load),
    .add_val(n_msgs),
    .count  (pending_cnt)
  );

  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    err_lowprio |-> !local_req && !msg_valid) // R8
    else $error("lowest-priority request produced output");
  AST_DEST_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> ({1'b0, msg_dest} < num_proc)) // R2
    else $error("message to absent processor");
  AST_NO_SELF_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_dest != self_id) // R3
    else $error("message sent to own ID");
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_wr |=> !local_req && !err_lowprio) // R11
    else $error("write accepted while busy");
endmodule

// File: tb/ipi_dest_resolver_test.sv
module ipi_dest_resolver_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_wr = 1'b0;
  logic [1:0] cmd_shorthand = '0;
  logic       cmd_dest_logical = 1'b0;
  logic [7:0] cmd_dest = '0;
  logic [2:0] cmd_dmode = '0;
  logic [7:0] cmd_vector = '0;
  logic       cmd_trigger = 1'b0;
  logic       cmd_level = 1'b0;
  logic [2:0] self_id = '0;
  logic [3:0] num_proc = 4'd8;
  logic       local_req, local_trigger, err_lowprio, busy, msg_valid;
  logic       msg_ready = 1'b0;
  logic [7:0] local_vector, msg_vector;
  logic [2:0] local_dmode, msg_dmode, msg_dest;
  logic       msg_trigger, msg_level;
  logic [7:0] pending_cnt;

  int checks = 0;
  int errors = 0;
  int cnt_model = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  ipi_dest_resolver uut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_shorthand(cmd_shorthand),
    .cmd_dest_logical(cmd_dest_logical), .cmd_dest(cmd_dest), .cmd_dmode(cmd_dmode),
    .cmd_vector(cmd_vector), .cmd_trigger(cmd_trigger), .cmd_level(cmd_level),
    .self_id(self_id), .num_proc(num_proc), .local_req(local_req),
    .local_vector(local_vector), .local_dmode(local_dmode), .local_trigger(local_trigger),
    .err_lowprio(err_lowprio), .busy(busy), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_dest(msg_dest), .msg_vector(msg_vector), .msg_dmode(msg_dmode),
    .msg_trigger(msg_trigger), .msg_level(msg_level), .pending_cnt(pending_cnt)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [1:0] sh, input logic lg, input logic [7:0] d,
                         input logic [2:0] dm, input logic [7:0] vec,
                         input logic trg, input logic lvl, input string req);
    logic [7:0] em;
    bit es, ee, first;
    int nc, me, pop;
    nc = int'(num_proc);
    me = int'(self_id);
    em = '0; es = 0; ee = 0;
    if (sh == 2'd0) begin
      if (dm == 3'd1) ee = 1;
      else if (lg) begin
        for (int i = 0; i < nc; i++)
          if (d[i]) begin
            if (i == me) es = 1; else em[i] = 1'b1;
          end
      end else if (d == 8'hFF) begin
        es = 1;
        for (int i = 0; i < nc; i++) if (i != me) em[i] = 1'b1;
      end else if (int'(d) == me) es = 1;
      else if (int'(d) < nc) em[d[2:0]] = 1'b1;
    end else begin
      es = (sh != 2'd3);
      if (sh != 2'd1)
        for (int i = 0; i < nc; i++) if (i != me) em[i] = 1'b1;
    end
    pop = $countones(em);
    if (!ee) cnt_model = (cnt_model + pop > 255) ? 255 : cnt_model + pop;

    @(negedge clk);
    cmd_shorthand = sh; cmd_dest_logical = lg; cmd_dest = d; cmd_dmode = dm;
    cmd_vector = vec; cmd_trigger = trg; cmd_level = lvl; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    chk(local_req == es, es ? "R12" : req, "local_req", int'(local_req), int'(es));
    if (es) begin
      chk(local_vector == vec && local_dmode == dm && local_trigger == trg, "R12",
          "local fields", int'(local_vector), int'(vec));
    end
    chk(err_lowprio == ee, "R8", "err_lowprio", int'(err_lowprio), int'(ee));
    chk(int'(pending_cnt) == cnt_model, "R9", "pending_cnt", int'(pending_cnt), cnt_model);
    chk(busy == (em != 0), req, "busy", int'(busy), int'(em != 0));

    first = 1;
    while (msg_valid) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      msg_ready = lfsr[0] | lfsr[3];
      if (first) begin
        cmd_shorthand = 2'd2; cmd_wr = 1'b1;
      end
      if (msg_ready) begin
        int exp_d;
        exp_d = 0;
        for (int i = 7; i >= 0; i--) if (em[i]) exp_d = i;
        chk(em != 0 && int'(msg_dest) == exp_d, req, "msg_dest (R10 order)",
            int'(msg_dest), exp_d);
        chk(msg_vector == vec && msg_dmode == dm && msg_trigger == trg && msg_level == lvl,
            "R10", "msg fields", int'(msg_vector), int'(vec));
        em[exp_d] = 1'b0;
      end
      @(negedge clk);
      cmd_wr = 1'b0;
      msg_ready = 1'b0;
      if (first) begin
        chk(!local_req, "R11", "local_req after busy write", int'(local_req), 0);
        chk(int'(pending_cnt) == cnt_model, "R11", "pending_cnt after busy write",
            int'(pending_cnt), cnt_model);
        first = 0;
      end
    end
    chk(em == 0, req, "undelivered targets (R10)", int'(em), 0);
    chk(!busy, "R10", "busy after drain", int'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int ncs[3];
    ncs[0] = 8; ncs[1] = 5; ncs[2] = 3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!local_req && !err_lowprio && !msg_valid && !busy && pending_cnt == 0, "R1",
        "reset state", int'(pending_cnt), 0);
    foreach (ncs[k]) begin
      for (int s = 0; s < 3; s++) begin
        int me;
        me = (s == 0) ? 0 : (s == 1) ? ncs[k] / 2 : ncs[k] - 1;
        num_proc = 4'(ncs[k]);
        self_id = 3'(me);
        for (int d = 0; d < 256; d++)
          run_cmd(2'd0, 1'b1, 8'(d), {d[2], 2'b00}, 8'(d) ^ 8'h5A, d[0], d[1], "R2");
        for (int d = 0; d < 256; d++)
          run_cmd(2'd0, 1'b0, 8'(d), {d[3], 2'b00}, 8'(d) ^ 8'hC3, d[1], d[0],
                  (d == 255) ? "R3" : "R4");
        run_cmd(2'd0, 1'b0, 8'h01, 3'd1, 8'h11, 1'b0, 1'b0, "R8");
        run_cmd(2'd0, 1'b1, 8'hFF, 3'd1, 8'h12, 1'b1, 1'b0, "R8");
        run_cmd(2'd0, 1'b0, 8'hFF, 3'd1, 8'h13, 1'b0, 1'b1, "R8");
        run_cmd(2'd1, 1'b0, 8'h00, 3'd1, 8'h21, 1'b1, 1'b0, "R5");
        run_cmd(2'd1, 1'b1, 8'hFF, 3'd0, 8'h22, 1'b0, 1'b1, "R5");
        run_cmd(2'd2, 1'b0, 8'h03, 3'd1, 8'h31, 1'b1, 1'b1, "R6");
        run_cmd(2'd2, 1'b1, 8'h00, 3'd4, 8'h32, 1'b0, 1'b0, "R6");
        run_cmd(2'd3, 1'b0, 8'h00, 3'd1, 8'h41, 1'b0, 1'b1, "R7");
        run_cmd(2'd3, 1'b1, 8'hFF, 3'd0, 8'h42, 1'b1, 1'b0, "R7");
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule